// File: doc/BRIEF.md
# SPI Master with Automatic Select Timing

This block is a byte-wide SPI master controlled through one 16-bit configuration word. It divides a 48 MHz system clock into a serial clock of twelve selectable rates. Clock polarity and clock phase are each selectable. Data can move on two separate lines in full duplex, or on one shared bidirectional line in three-wire mode.

Software writes the configuration word, then writes a byte to start a transfer. The block drives the select line in one of two modes:
- In automatic mode, it lowers select, waits a programmable gap, clocks eight bits out most significant first while shifting eight bits in, waits the same gap, raises select, and then holds select high for the same gap before it reports idle.
- In manual mode, the select line simply follows an input pin.

A busy flag is returned in the readback word. The master/slave choice cannot be changed while that flag is set. Each output has its own drive-enable so that the pad ring can tri-state it.

Top module: `spi_xfer_ctrl`

## Requirements
- R1: While reset is asserted, the readback word is 0, `sck_oe`, `mosi_oe` and `ss_oe` are 0, and `sck_o` rests high.
- R2: Field [12:9] selects the serial clock rate from 48 MHz. Codes 0 to 11 give 12, 8, 6, 4, 3, 2, 1.5, 1 MHz, 750, 500, 375 and 250 kHz. Codes 12 to 15 give 250 kHz. One half-bit time is 24 MHz divided by the rate, counted in clock cycles.
- R3: Bit 13 sets polarity: 1 means `sck_o` rests low, 0 means it rests high. Bit 14 sets phase: 0 samples on the first (leading) edge of each bit, and 1 changes data on the leading edge and samples on the trailing edge.
- R4: A transfer shifts 8 bits, most significant bit first, on `mosi_o`. In full duplex (bit 15 = 0) it shifts 8 bits in from `miso_i`. The received byte appears on `rx_data` once the transfer has ended.
- R5: With bit 15 = 1, the received bits come from `mosi_i`. Bit 8 selects the direction of the shared line: when it is 1, `mosi_oe` is 0.
- R6: With a nonzero gap field N in bits [4:0], select falls when the transfer begins. The first clock edge follows N half-bit times later, and select rises N half-bit times after the last clock edge. Select then stays high for N more half-bit times before the block goes idle. Select is high whenever the block is idle.
- R7: With the gap field at 0, `ss_o` follows `ss_man`. The gaps before the first clock edge and after the last one are each one half-bit time, and no high-time gap follows.
- R8: Readback bit 7 is 1 from the clock edge that accepts a byte write until the select high-time gap ends. A byte write is ignored while the flag is 1.
- R9: Bit 6 (1 = master) keeps its value when the configuration is written while bit 7 is 1. The other fields take the written value.
- R10: `ss_oe` equals bit 5. With bit 6 = 0, `sck_oe` and `mosi_oe` are 0 and a byte write starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 48 MHz system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration write value |
| cfg_rdata | output | 16 | Configuration readback with busy flag in bit 7 |
| tx_wr | input | 1 | Byte write strobe; starts a transfer |
| tx_data | input | DATA_W | Byte to send |
| rx_data | output | DATA_W | Last byte received |
| ss_man | input | 1 | Select level used in manual mode |
| sck_o | output | 1 | Serial clock |
| sck_oe | output | 1 | Serial clock drive enable |
| mosi_o | output | 1 | Serial data out (shared line in three-wire mode) |
| mosi_oe | output | 1 | Serial data out drive enable |
| mosi_i | input | 1 | Shared line input in three-wire mode |
| miso_i | input | 1 | Serial data in for full duplex |
| ss_o | output | 1 | Slave select, active low |
| ss_oe | output | 1 | Slave select drive enable |

## Verification
The assertions assume three things:
- The configuration word is rewritten during a transfer only to try to flip the master bit. Polarity, rate and gap stay as they were.
- A configuration write and a byte write never fall in the same cycle.
- The serial clock can change during an automatic-mode frame only while select is low.

The stimulus keeps to these assumptions. It writes new settings only after the busy flag has cleared, and its one mid-transfer write copies every field except the master bit. The bench's reference model drives the serial input pins from the edge count it predicts, so each bit is stable across its sampling edge.

// File: rtl/spi_xfer_pkg.sv
`timescale 1ns/1ps
package spi_xfer_pkg;

  localparam int HALF_W = 7;
  localparam int GAP_W  = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_SHIFT,
    ST_TRAIL,
    ST_GAP
  } seq_st_e;

  // Field positions follow the readback word layout.
  typedef struct packed {
    logic             three;
    logic             pha;
    logic             pol;
    logic [3:0]       rate;
    logic             dir_rx;
    logic             busy;
    logic             master;
    logic             ss_en;
    logic [GAP_W-1:0] gap;
  } spi_cfg_t;

  // Half serial-clock period in system cycles, per rate code.
  function automatic logic [HALF_W-1:0] half_period(input logic [3:0] rate);
    logic [HALF_W-1:0] h;
    case (rate)
      4'd0:    h = 7'd2;
      4'd1:    h = 7'd3;
      4'd2:    h = 7'd4;
      4'd3:    h = 7'd6;
      4'd4:    h = 7'd8;
      4'd5:    h = 7'd12;
      4'd6:    h = 7'd16;
      4'd7:    h = 7'd24;
      4'd8:    h = 7'd32;
      4'd9:    h = 7'd48;
      4'd10:   h = 7'd64;
      default: h = 7'd96;
    endcase
    return h;
  endfunction

endpackage

// File: rtl/spi_tick_gen.sv
`timescale 1ns/1ps
module spi_tick_gen #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] half,
  output logic         tick
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         wrap;

  assign wrap = (cnt_q == (half - W'(1)));
  assign tick = en & wrap;

  always_comb begin
    cnt_d = cnt_q;
    if (!en)       cnt_d = '0;
    else if (wrap) cnt_d = '0;
    else           cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/spi_seq.sv
`timescale 1ns/1ps
module spi_seq
  import spi_xfer_pkg::*;
#(
  parameter int EDGES  = 16,
  parameter int ECNT_W = $clog2(EDGES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              tick,
  input  logic [GAP_W-1:0]  gap,
  output seq_st_e           state,
  output logic              edge_stb,
  output logic [ECNT_W-1:0] edge_idx
);

  seq_st_e           st_q, st_d;
  logic [GAP_W-1:0]  tcnt_q, tcnt_d;
  logic [ECNT_W-1:0] ecnt_q, ecnt_d;
  logic [GAP_W-1:0]  frame_n;

  // Manual mode still keeps one half-bit before and after the clocks.
  assign frame_n = (gap == '0) ? GAP_W'(1) : gap;
  assign state   = st_q;

  always_comb begin
    st_d     = st_q;
    tcnt_d   = tcnt_q;
    ecnt_d   = ecnt_q;
    edge_stb = 1'b0;
    edge_idx = ecnt_q;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d   = ST_LEAD;
          tcnt_d = '0;
          ecnt_d = '0;
        end
      end
      ST_LEAD: begin
        if (tick) begin
          if (tcnt_q == frame_n - GAP_W'(1)) begin
            st_d     = ST_SHIFT;
            tcnt_d   = '0;
            edge_stb = 1'b1;
            edge_idx = '0;
            ecnt_d   = ECNT_W'(1);
          end else begin
            tcnt_d = tcnt_q + GAP_W'(1);
          end
        end
      end
      ST_SHIFT: begin
        if (tick) begin
          edge_stb = 1'b1;
          if (ecnt_q == ECNT_W'(EDGES - 1)) begin
            st_d   = ST_TRAIL;
            tcnt_d = '0;
          end else begin
            ecnt_d = ecnt_q + ECNT_W'(1);
          end
        end
      end
      ST_TRAIL: begin
        if (tick) begin
          if (tcnt_q == frame_n - GAP_W'(1)) begin
            tcnt_d = '0;
            st_d   = (gap == '0) ? ST_IDLE : ST_GAP;
          end else begin
            tcnt_d = tcnt_q + GAP_W'(1);
          end
        end
      end
      ST_GAP: begin
        if (tick) begin
          if (tcnt_q == gap - GAP_W'(1)) begin
            tcnt_d = '0;
            st_d   = ST_IDLE;
          end else begin
            tcnt_d = tcnt_q + GAP_W'(1);
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      tcnt_q <= '0;
      ecnt_q <= '0;
    end else begin
      st_q   <= st_d;
      tcnt_q <= tcnt_d;
      ecnt_q <= ecnt_d;
    end
  end

endmodule

// File: rtl/spi_shifter.sv
`timescale 1ns/1ps
module spi_shifter #(
  parameter int DW     = 8,
  parameter int ECNT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DW-1:0]     load_data,
  input  logic              edge_stb,
  input  logic [ECNT_W-1:0] edge_idx,
  input  logic              cpha,
  input  logic              sdi,
  output logic              sdo,
  output logic              sck_ph,
  output logic [DW-1:0]     rx_data
);

  logic [DW-1:0] tx_q, tx_d, rx_q, rx_d;
  logic          ph_q, ph_d;
  logic          leading, do_sample, do_shift;

  assign leading   = ~edge_idx[0];
  assign do_sample = edge_stb & (cpha ? ~leading : leading);
  assign do_shift  = edge_stb & (cpha ? (leading & (edge_idx != '0)) : ~leading);

  always_comb begin
    tx_d = tx_q;
    rx_d = rx_q;
    ph_d = ph_q;
    if (load) begin
      tx_d = load_data;
      ph_d = 1'b0;
    end else begin
      if (do_shift)  tx_d = {tx_q[DW-2:0], 1'b0};
      if (do_sample) rx_d = {rx_q[DW-2:0], sdi};
      if (edge_stb)  ph_d = ~ph_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
      ph_q <= 1'b0;
    end else begin
      tx_q <= tx_d;
      rx_q <= rx_d;
      ph_q <= ph_d;
    end
  end

  assign sdo     = tx_q[DW-1];
  assign sck_ph  = ph_q;
  assign rx_data = rx_q;

endmodule

// File: rtl/spi_xfer_ctrl.sv
`timescale 1ns/1ps
module spi_xfer_ctrl
  import spi_xfer_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [15:0]       cfg_wdata,
  output logic [15:0]       cfg_rdata,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_data,
  output logic [DATA_W-1:0] rx_data,
  input  logic              ss_man,
  output logic              sck_o,
  output logic              sck_oe,
  output logic              mosi_o,
  output logic              mosi_oe,
  input  logic              mosi_i,
  input  logic              miso_i,
  output logic              ss_o,
  output logic              ss_oe
);

  localparam int EDGES  = 2 * DATA_W;
  localparam int ECNT_W = $clog2(EDGES);

  spi_cfg_t          cfg_q, cfg_d;
  seq_st_e           state;
  logic              active, start, tick, edge_stb, sck_ph, sdi, framing;
  logic [ECNT_W-1:0] edge_idx;
  logic [HALF_W-1:0] half;

  assign active = (state != ST_IDLE);
  assign start  = tx_wr & ~active & cfg_q.master;
  assign half   = half_period(cfg_q.rate);

  always_comb begin
    cfg_d = cfg_q;
    if (cfg_wr) begin
      cfg_d      = spi_cfg_t'(cfg_wdata);
      cfg_d.busy = 1'b0;
      if (active) cfg_d.master = cfg_q.master;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  spi_tick_gen #(.W(HALF_W)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (active),
    .half (half),
    .tick (tick)
  );

  spi_seq #(.EDGES(EDGES), .ECNT_W(ECNT_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .tick    (tick),
    .gap     (cfg_q.gap),
    .state   (state),
    .edge_stb(edge_stb),
    .edge_idx(edge_idx)
  );

  assign sdi = cfg_q.three ? mosi_i : miso_i;

  spi_shifter #(.DW(DATA_W), .ECNT_W(ECNT_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start),
    .load_data(tx_data),
    .edge_stb (edge_stb),
    .edge_idx (edge_idx),
    .cpha     (cfg_q.pha),
    .sdi      (sdi),
    .sdo      (mosi_o),
    .sck_ph   (sck_ph),
    .rx_data  (rx_data)
  );

  assign framing   = (state == ST_LEAD) | (state == ST_SHIFT) | (state == ST_TRAIL);
  assign ss_o      = (cfg_q.gap == '0) ? ss_man : ~framing;
  assign ss_oe     = cfg_q.ss_en;
  assign sck_o     = cfg_q.pol ? sck_ph : ~sck_ph;
  assign sck_oe    = cfg_q.master;
  assign mosi_oe   = cfg_q.master & ~(cfg_q.three & cfg_q.dir_rx);
  assign cfg_rdata = 16'(cfg_q) | {8'd0, active, 7'd0};

endmodule

// File: rtl/spi_xfer_ctrl_sva.sv
`timescale 1ns/1ps
module spi_xfer_ctrl_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_wr,
  input logic [15:0] cfg_rdata,
  input logic        tx_wr,
  input logic        sck_o,
  input logic        sck_oe,
  input logic        ss_o,
  input logic        mosi_oe
);

  logic busy, master, auto_ss;
  assign busy    = cfg_rdata[7];
  assign master  = cfg_rdata[6];
  assign auto_ss = (cfg_rdata[4:0] != 5'd0);

  p_master_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cfg_wr) |=> $stable(cfg_rdata[6]));

  p_start_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && tx_wr && master) |=> busy);

  p_slave_no_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !master) |=> !busy);

  p_slave_float_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !master |-> (!sck_oe && !mosi_oe));

  p_sck_rest_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sck_o == !cfg_rdata[13]));

  p_ss_high_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && auto_ss) |-> ss_o);

  p_ss_frames_sck_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_ss && !$stable(sck_o) && !$past(cfg_wr)) |-> !ss_o);

  p_shared_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[15] && cfg_rdata[8]) |-> !mosi_oe);

endmodule

bind spi_xfer_ctrl spi_xfer_ctrl_sva u_sva (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_wr   (cfg_wr),
  .cfg_rdata(cfg_rdata),
  .tx_wr    (tx_wr),
  .sck_o    (sck_o),
  .sck_oe   (sck_oe),
  .ss_o     (ss_o),
  .mosi_oe  (mosi_oe)
);

// File: tb/spi_xfer_ctrl_tb.sv
`timescale 1ns/1ps
module spi_xfer_ctrl_tb;

  logic        clk;
  logic        rst_n;
  logic        cfg_wr;
  logic [15:0] cfg_wdata;
  logic [15:0] cfg_rdata;
  logic        tx_wr;
  logic [7:0]  tx_data;
  logic [7:0]  rx_data;
  logic        ss_man;
  logic        sck_o, sck_oe, mosi_o, mosi_oe, mosi_i, miso_i, ss_o, ss_oe;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  spi_xfer_ctrl #(.DATA_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .tx_wr(tx_wr), .tx_data(tx_data), .rx_data(rx_data),
    .ss_man(ss_man), .sck_o(sck_o), .sck_oe(sck_oe), .mosi_o(mosi_o),
    .mosi_oe(mosi_oe), .mosi_i(mosi_i), .miso_i(miso_i), .ss_o(ss_o), .ss_oe(ss_oe)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Rate table in kHz, from the requirement; half-bit = 24 MHz / rate.
  function automatic int half_of(input logic [3:0] code);
    int r;
    case (code)
      4'd0: r = 12000;  4'd1: r = 8000;  4'd2: r = 6000;  4'd3: r = 4000;
      4'd4: r = 3000;   4'd5: r = 2000;  4'd6: r = 1500;  4'd7: r = 1000;
      4'd8: r = 750;    4'd9: r = 500;   4'd10: r = 375;  default: r = 250;
    endcase
    return 24000 / r;
  endfunction

  function automatic logic [15:0] mk(input bit three, input bit pha, input bit pol,
                                     input logic [3:0] code, input bit dir, input bit master,
                                     input bit ss_en, input logic [4:0] gap);
    return {three, pha, pol, code, dir, 1'b0, master, ss_en, gap};
  endfunction

  // ---------------- reference model ----------------
  logic [15:0] m_cfg;
  logic [7:0]  m_tx, m_pat, m_rx_exp, rx_pat;
  bit          m_busy, m_pha, m_pol, was_busy;
  int          m_k, m_H, m_L, m_T, m_G;

  function automatic int edges_done();
    int m, e;
    m = m_k / m_H;
    e = (m >= m_L) ? (m - m_L + 1) : 0;
    if (e > 16) e = 16;
    return e;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cfg = '0; m_busy = 0; m_k = 0; m_H = 2; m_L = 1; m_T = 1; m_G = 0;
      m_rx_exp = '0; m_tx = '0; m_pat = '0; m_pha = 0; m_pol = 0;
    end else begin
      was_busy = m_busy;
      if (m_busy) begin
        m_k++;
        if (m_k >= (m_L + 15 + m_T + m_G) * m_H) begin
          m_busy   = 0;
          m_rx_exp = m_pat;
        end
      end
      if (tx_wr && !was_busy && m_cfg[6]) begin
        m_busy = 1; m_k = 0;
        m_H    = half_of(m_cfg[12:9]);
        m_G    = int'(m_cfg[4:0]);
        m_L    = (m_G == 0) ? 1 : m_G;
        m_T    = m_L;
        m_pha  = m_cfg[14]; m_pol = m_cfg[13];
        m_tx   = tx_data;   m_pat = rx_pat;
      end
      if (cfg_wr) begin
        logic [15:0] nc;
        nc    = cfg_wdata;
        nc[7] = 1'b0;
        if (was_busy) nc[6] = m_cfg[6];
        m_cfg = nc;
      end
    end
  end

  // Slave side: present each received bit ahead of its sampling edge.
  always @(negedge clk) begin
    if (m_busy) begin
      int e, idx;
      logic b;
      e   = edges_done();
      idx = m_pha ? (e / 2) : ((e + 1) / 2);
      if (idx > 7) idx = 7;
      b = m_pat[7 - idx];
      if (m_cfg[15]) begin mosi_i = b; miso_i = ~b; end
      else           begin miso_i = b; mosi_i = ~b; end
    end else begin
      mosi_i = 1'b0; miso_i = 1'b0;
    end
  end

  // Cycle-by-cycle comparison
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int e, m, sh;
      bit ph, manual;
      logic exp_ss;
      manual = (m_cfg[4:0] == 5'd0);
      if (m_busy) begin
        e  = edges_done();
        m  = m_k / m_H;
        ph = e[0];
        chk("R2 R3 sck", {15'd0, sck_o}, {15'd0, m_pol ? ph : ~ph});
        sh = m_pha ? ((e >= 1) ? ((e + 1) / 2 - 1) : 0) : (e / 2);
        if (sh < 8) chk("R4 mosi", {15'd0, mosi_o}, {15'd0, m_tx[7 - sh]});
        exp_ss = (m < m_L + 15 + m_T) ? 1'b0 : 1'b1;
      end else begin
        chk("R3 sck rest", {15'd0, sck_o}, {15'd0, ~m_cfg[13]});
        chk("R4 R5 rx", {8'd0, rx_data}, {8'd0, m_rx_exp});
        exp_ss = 1'b1;
      end
      if (manual) chk("R7 ss", {15'd0, ss_o}, {15'd0, ss_man});
      else        chk("R6 ss", {15'd0, ss_o}, {15'd0, exp_ss});
      chk("R8 R9 rdata", cfg_rdata, m_cfg | {8'd0, m_busy, 7'd0});
      chk("R5 R10 mosi_oe", {15'd0, mosi_oe}, {15'd0, m_cfg[6] & ~(m_cfg[15] & m_cfg[8])});
      chk("R10 sck_oe", {15'd0, sck_oe}, {15'd0, m_cfg[6]});
      chk("R10 ss_oe", {15'd0, ss_oe}, {15'd0, m_cfg[5]});
    end
  end

  // ---------------- stimulus ----------------
  task automatic write_cfg(input logic [15:0] v);
    @(negedge clk); cfg_wr = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic send(input logic [7:0] d, input logic [7:0] pat);
    @(negedge clk); tx_wr = 1'b1; tx_data = d; rx_pat = pat;
    @(negedge clk); tx_wr = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (m_busy);
  endtask

  initial begin
    rst_n = 1'b0; cfg_wr = 0; cfg_wdata = '0; tx_wr = 0; tx_data = '0;
    ss_man = 1'b1; rx_pat = '0; mosi_i = 0; miso_i = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 rdata", cfg_rdata, 16'h0000);
    chk("R1 sck_oe", {15'd0, sck_oe}, 16'd0);
    chk("R1 mosi_oe", {15'd0, mosi_oe}, 16'd0);
    chk("R1 ss_oe", {15'd0, ss_oe}, 16'd0);
    chk("R1 sck", {15'd0, sck_o}, 16'd1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Fastest rate, rest low, sample on leading edge, gap 1
    write_cfg(mk(0, 0, 1, 4'd0, 0, 1, 1, 5'd1));
    send(8'hA5, 8'h3C); wait_idle();
    // Advanced phase, rest high, 4 MHz, gap 3
    write_cfg(mk(0, 1, 0, 4'd3, 0, 1, 1, 5'd3));
    send(8'h5A, 8'hC9); wait_idle();
    // Three-wire, transmit direction then receive direction (R5)
    write_cfg(mk(1, 0, 1, 4'd1, 0, 1, 1, 5'd2));
    send(8'h96, 8'h00); wait_idle();
    write_cfg(mk(1, 1, 1, 4'd1, 1, 1, 1, 5'd2));
    send(8'h00, 8'hB7); wait_idle();
    // Manual select (R7)
    write_cfg(mk(0, 0, 0, 4'd2, 0, 1, 1, 5'd0));
    @(negedge clk); ss_man = 1'b0;
    send(8'h81, 8'h7E); wait_idle();
    @(negedge clk); ss_man = 1'b1;
    // Back-to-back with write while busy ignored (R8), gap 2
    write_cfg(mk(0, 1, 1, 4'd0, 0, 1, 1, 5'd2));
    send(8'h12, 8'h34);
    repeat (10) @(negedge clk);
    send(8'hFF, 8'hFF);
    wait_idle();
    send(8'h6C, 8'h9A);
    // Master bit held while busy (R9)
    repeat (6) @(negedge clk);
    write_cfg(mk(0, 1, 1, 4'd0, 0, 0, 1, 5'd2));
    wait_idle();
    // Saturated rate code, largest divide (R2)
    write_cfg(mk(0, 0, 0, 4'd14, 0, 1, 0, 5'd1));
    send(8'hC3, 8'h5D); wait_idle();
    // Slave mode: byte write does nothing (R10)
    write_cfg(mk(0, 0, 0, 4'd0, 0, 0, 1, 5'd1));
    send(8'hAA, 8'h55);
    repeat (20) @(negedge clk);
    chk("R10 no start", {15'd0, cfg_rdata[7]}, 16'd0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule